// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial bit stream. Characters of five to nine bits are written into a two-slot holding buffer. A single shift engine takes them out in the order they were written and sends each one as a frame: a low start bit, the data bits least significant first, an optional parity bit, and a stop period at the high level. The frame format comes from a configuration word, and the block samples that word once at the start of each frame. Bit timing comes from a one-cycle baud tick at sixteen times the bit rate. Each bit lasts sixteen ticks.

Software controls the block with single-cycle enable and disable command pulses. It watches three level flags: transmitter on, buffer level and transmission complete. A buffer-level select bit chooses whether the level flag means "buffer empty" or "room for one more character". A sticky completion interrupt flag has its own set and clear pulses and an enable mask.

The shift engine is a five-state machine. IDLE goes to START when the transmitter is on and the buffer holds a character. START goes to DATA after one bit time. DATA stays in DATA until the last data bit has ended. It then goes to PARITY when parity is on, and to STOP otherwise. PARITY goes to STOP after one bit time. STOP goes back to IDLE when the stop period ends.

Top module: `sertx_core`

## Requirements
- R1: The line idles high. A frame is one low start bit followed by the data bits, least significant first. Each bit lasts 16 baud ticks. The data count is taken from `frame_cfg[3:0]` plus 3, so code 2 gives 5 bits and code 6 gives 9 bits. Codes below 2 act as 5 bits and codes above 6 act as 9 bits.
- R2: The parity code `frame_cfg[9:8]` selects the parity bit, sent after the data bits. Code 0 (and 1) means no parity bit. Code 2 means even parity and code 3 means odd parity, each over the sent data bits.
- R3: The stop code `frame_cfg[13:12]` sets the length of the high stop period. Code 0 gives 8 ticks, code 1 (and 2) gives 16 ticks, and code 3 gives 32 ticks.
- R4: The buffer holds two characters and sends them in the order they were written. A write while the buffer is full is dropped.
- R5: When `lvl_sel` is 0, `st_buf_lvl` is high only while the buffer is empty. When `lvl_sel` is 1, it is high while at least one slot is free.
- R6: A `cmd_tx_en` pulse turns the transmitter on and a `cmd_tx_dis` pulse turns it off. The off command wins when both arrive together. `st_tx_on` shows the current state. A new frame starts only while the transmitter is on. A frame already in progress still finishes after the off command.
- R7: `st_tx_done` goes high when a frame ends and the buffer is empty. An accepted write clears it. It stays low while the buffer still holds characters.
- R8: `irq_flag` is set when `st_tx_done` rises or when `irq_set` pulses. It stays set until an `irq_clr` pulse, and a set event wins over a clear in the same cycle. `irq_out` is `irq_flag` gated by `irq_mask`.
- R9: After reset the line is high, the transmitter is off, the buffer is empty, `st_tx_done` is low and `irq_flag` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 9 | Character; bits above the frame's data count are ignored |
| frame_cfg | input | 16 | Frame format: [3:0] data count minus 3, [9:8] parity, [13:12] stop |
| cmd_tx_en | input | 1 | Transmitter-on command pulse |
| cmd_tx_dis | input | 1 | Transmitter-off command pulse |
| lvl_sel | input | 1 | Meaning of buffer-level flag: 0 empty, 1 slot free |
| baud_tick | input | 1 | One-cycle pulse at 16x bit rate |
| txd | output | 1 | Serial output line |
| st_tx_on | output | 1 | Transmitter on |
| st_buf_lvl | output | 1 | Buffer level flag |
| st_tx_done | output | 1 | Last frame finished and buffer empty |
| irq_set | input | 1 | Sets the completion interrupt flag |
| irq_clr | input | 1 | Clears the completion interrupt flag |
| irq_mask | input | 1 | Interrupt enable |
| irq_flag | output | 1 | Sticky completion interrupt flag |
| irq_out | output | 1 | Masked interrupt request |

## Verification
A wrong state in the shift engine shows on `txd` within one bit time. It appears as a misplaced edge, a wrong bit at a bit centre, or a frame whose length in ticks differs from the configured count. A wrong buffer count shows on `st_buf_lvl` in the very next cycle. Over the longer run it shows as a missing, repeated or extra frame. A wrong completion or enable state shows as a frame that starts while the transmitter is off, or as `st_tx_done` rising while a character is still waiting, one clock after the frame's last tick.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int TICKS_PER_BIT = 16;
    localparam int MAX_DATA_W    = 9;
    localparam int TCNT_W        = 6;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_t;

    typedef struct packed {
        logic [3:0]        nbits;
        logic              par_en;
        logic              par_odd;
        logic [TCNT_W-1:0] stop_ticks;
    } fmt_t;

    function automatic fmt_t decode_fmt(input logic [15:0] cfg);
        fmt_t f;
        if (cfg[3:0] < 4'd2)      f.nbits = 4'd5;
        else if (cfg[3:0] > 4'd6) f.nbits = 4'd9;
        else                      f.nbits = cfg[3:0] + 4'd3;
        f.par_en  = cfg[9];
        f.par_odd = cfg[9] & cfg[8];
        unique case (cfg[13:12])
            2'd0:    f.stop_ticks = TCNT_W'(TICKS_PER_BIT / 2);
            2'd3:    f.stop_ticks = TCNT_W'(TICKS_PER_BIT * 2);
            default: f.stop_ticks = TCNT_W'(TICKS_PER_BIT);
        endcase
        return f;
    endfunction
endpackage

// File: rtl/sertx_hold_buf.sv
module sertx_hold_buf #(
    parameter int W     = 9,
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             full
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
    a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int DATA_W = MAX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    input  fmt_t              fmt_in,
    input  logic              tick,
    output logic              txd,
    output logic              busy,
    output logic              frame_done
);
    tx_state_t         st, st_nxt;
    fmt_t              fmt_q;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    logic [TCNT_W-1:0] tcnt;
    logic [3:0]        bidx;
    logic [TCNT_W-1:0] span;
    logic              last;
    logic [DATA_W-1:0] dmask;
    logic              par_calc;

    always_comb begin
        dmask = '0;
        for (int i = 0; i < DATA_W; i++)
            if (i < int'(fmt_in.nbits)) dmask[i] = 1'b1;
        par_calc = (^(din & dmask)) ^ fmt_in.par_odd;
    end

    assign span = (st == ST_STOP) ? fmt_q.stop_ticks : TCNT_W'(TICKS_PER_BIT);
    assign last = tick && (tcnt == span - 1'b1);

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:   if (start) st_nxt = ST_START;
            ST_START:  if (last)  st_nxt = ST_DATA;
            ST_DATA:   if (last && bidx == fmt_q.nbits - 4'd1)
                           st_nxt = fmt_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (last)  st_nxt = ST_STOP;
            ST_STOP:   if (last)  st_nxt = ST_IDLE;
            default:              st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
            fmt_q <= '0;
            par_q <= 1'b0;
        end else begin
            if (st == ST_IDLE || last) tcnt <= '0;
            else if (tick)             tcnt <= tcnt + 1'b1;
            if (st == ST_IDLE && start) begin
                shreg <= din;
                fmt_q <= fmt_in;
                par_q <= par_calc;
                bidx  <= '0;
            end else if (st == ST_DATA && last) begin
                shreg <= shreg >> 1;
                bidx  <= bidx + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (st)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
        busy       = (st != ST_IDLE);
        frame_done = (st == ST_STOP) && last;
    end

    a_r3_stop_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP) |-> (tcnt < fmt_q.stop_ticks));
    a_r1_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA) |-> (bidx < fmt_q.nbits));
endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int DATA_W = MAX_DATA_W,
    parameter int DEPTH  = 2,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [15:0]       frame_cfg,
    input  logic              cmd_tx_en,
    input  logic              cmd_tx_dis,
    input  logic              lvl_sel,
    input  logic              baud_tick,
    output logic              txd,
    output logic              st_tx_on,
    output logic              st_buf_lvl,
    output logic              st_tx_done,
    input  logic              irq_set,
    input  logic              irq_clr,
    input  logic              irq_mask,
    output logic              irq_flag,
    output logic              irq_out
);
    logic              en_q, done_q, done_d;
    logic [DATA_W-1:0] head;
    logic [LVL_W-1:0]  level;
    logic              buf_empty, buf_full;
    logic              sh_busy, sh_done, launch, accepted;

    assign launch   = en_q && !sh_busy && !buf_empty;
    assign accepted = wr_en && !buf_full;

    sertx_hold_buf #(.W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .wdata (wr_data),
        .pop   (launch),
        .rdata (head),
        .level (level),
        .empty (buf_empty),
        .full  (buf_full)
    );

    sertx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (launch),
        .din        (head),
        .fmt_in     (decode_fmt(frame_cfg)),
        .tick       (baud_tick),
        .txd        (txd),
        .busy       (sh_busy),
        .frame_done (sh_done)
    );

    always_comb begin
        done_d = done_q;
        if (accepted)                   done_d = 1'b0;
        else if (sh_done && buf_empty)  done_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            done_q   <= 1'b0;
            irq_flag <= 1'b0;
        end else begin
            if (cmd_tx_dis)     en_q <= 1'b0;
            else if (cmd_tx_en) en_q <= 1'b1;
            done_q <= done_d;
            if ((done_d && !done_q) || irq_set) irq_flag <= 1'b1;
            else if (irq_clr)                   irq_flag <= 1'b0;
        end
    end

    assign st_tx_on   = en_q;
    assign st_tx_done = done_q;
    assign st_buf_lvl = lvl_sel ? (level < LVL_W'(DEPTH)) : buf_empty;
    assign irq_out    = irq_flag & irq_mask;

    a_r6_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_busy) |-> $past(en_q));
    a_r7_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
        st_tx_done |-> (buf_empty && !sh_busy));
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);
    a_r7_done_rise_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_tx_done) |-> irq_flag);
endmodule

// File: tb/test_sertx_core.sv
module test_sertx_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [15:0] frame_cfg = '0;
    logic       cmd_tx_en = 1'b0, cmd_tx_dis = 1'b0, lvl_sel = 1'b0, baud_tick = 1'b0;
    logic       irq_set = 1'b0, irq_clr = 1'b0, irq_mask = 1'b0;
    logic       txd, st_tx_on, st_buf_lvl, st_tx_done, irq_flag, irq_out;

    int total = 0, bad = 0, frames_seen = 0;
    int cur_nb = 8, cur_par = 0, cur_stp = 16;

    typedef struct { logic [8:0] d; int nb; int par; int stp; bit chk_len; } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    sertx_core i_sertx_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .frame_cfg(frame_cfg), .cmd_tx_en(cmd_tx_en), .cmd_tx_dis(cmd_tx_dis),
        .lvl_sel(lvl_sel), .baud_tick(baud_tick), .txd(txd), .st_tx_on(st_tx_on),
        .st_buf_lvl(st_buf_lvl), .st_tx_done(st_tx_done), .irq_set(irq_set),
        .irq_clr(irq_clr), .irq_mask(irq_mask), .irq_flag(irq_flag), .irq_out(irq_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin : tick_gen
        int ph = 0;
        forever begin
            @(negedge clk);
            baud_tick = (ph == 3);
            ph = (ph + 1) % 4;
        end
    end

    task automatic set_cfg(input int nb, input int par, input int stp);
        logic [1:0] pc, sc;
        pc = (par == 0) ? 2'd0 : (par == 1) ? 2'd2 : 2'd3;
        sc = (stp == 8) ? 2'd0 : (stp == 16) ? 2'd1 : 2'd3;
        frame_cfg = {2'b00, sc, 2'b00, pc, 4'b0000, 4'(nb - 3)};
        cur_nb = nb; cur_par = par; cur_stp = stp;
    endtask

    task automatic wr(input logic [8:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic send(input logic [8:0] d, input bit chk_len);
        exp_t e;
        e.d = d; e.nb = cur_nb; e.par = cur_par; e.stp = cur_stp; e.chk_len = chk_len;
        q.push_back(e);
        wr(d);
    endtask

    task automatic pulse_en(input bit en, input bit dis);
        @(negedge clk); cmd_tx_en = en; cmd_tx_dis = dis;
        @(negedge clk); cmd_tx_en = 1'b0; cmd_tx_dis = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        @(negedge clk);
        while (!st_tx_done && n < 20000) begin @(negedge clk); n++; end
        chk(st_tx_done, "R7 completion reached", st_tx_done, 1);
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops expected frames and compares bit centres and frame length
    initial begin : monitor
        @(posedge rst_n);
        @(negedge clk);
        forever begin
            exp_t e;
            int cnt, pre, tlen;
            bit fin;
            logic [8:0] msk;
            logic pbit;
            while (txd !== 1'b0) @(negedge clk);
            if (q.size() == 0) begin
                chk(0, "R4 unexpected frame", 1, 0);
                e.d = '0; e.nb = 8; e.par = 0; e.stp = 16; e.chk_len = 0;
            end else e = q.pop_front();
            msk  = 9'((1 << e.nb) - 1);
            pbit = (^(e.d & msk)) ^ (e.par == 2);
            pre  = 16 * (1 + e.nb + (e.par != 0 ? 1 : 0));
            tlen = pre + e.stp;
            cnt = 0; fin = 0;
            while (!fin) begin
                if (cnt >= pre + 4 && (st_tx_done || !txd || cnt == tlen + 2)) fin = 1;
                else begin
                    if (baud_tick) begin
                        cnt++;
                        if (cnt == 8) chk(txd == 1'b0, "R1 start bit", txd, 0);
                        for (int k = 0; k < e.nb; k++)
                            if (cnt == 8 + 16 * (k + 1))
                                chk(txd == e.d[k], "R1 data bit", txd, e.d[k]);
                        if (e.par != 0 && cnt == 8 + 16 * (e.nb + 1))
                            chk(txd == pbit, "R2 parity bit", txd, pbit);
                        if (cnt == pre + 4) chk(txd == 1'b1, "R3 stop level", txd, 1);
                        if (e.stp == 32 && cnt == pre + 20)
                            chk(txd == 1'b1, "R3 second stop", txd, 1);
                    end
                    @(negedge clk);
                end
            end
            if (e.chk_len) chk(cnt == tlen, "R3 frame length in ticks", cnt, tlen);
            frames_seen++;
        end
    end

    initial begin : watchdog
        #(8 * 150000);
        chk(0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        int f0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(txd == 1'b1, "R9 line idle", txd, 1);
        chk(st_tx_on == 1'b0, "R9 tx off", st_tx_on, 0);
        chk(st_buf_lvl == 1'b1, "R9 buffer empty", st_buf_lvl, 1);
        chk(st_tx_done == 1'b0, "R9 done low", st_tx_done, 0);
        chk(irq_flag == 1'b0, "R9 irq clear", irq_flag, 0);

        // 8N1, fill buffer while off
        set_cfg(8, 0, 16);
        send(9'h0A5, 1);
        @(negedge clk);
        chk(st_buf_lvl == 1'b0, "R5 sel0 one entry", st_buf_lvl, 0);
        lvl_sel = 1'b1; @(negedge clk);
        chk(st_buf_lvl == 1'b1, "R5 sel1 one entry", st_buf_lvl, 1);
        send(9'h03C, 1);
        @(negedge clk);
        chk(st_buf_lvl == 1'b0, "R5 sel1 full", st_buf_lvl, 0);
        wr(9'h0FF);                           // R4 dropped write
        repeat (200) @(negedge clk);
        chk(txd == 1'b1 && frames_seen == 0, "R6 no frame while off", txd, 1);
        chk(st_tx_done == 1'b0, "R7 done low with data waiting", st_tx_done, 0);
        lvl_sel = 1'b0;
        pulse_en(1, 0);
        chk(st_tx_on == 1'b1, "R6 tx on", st_tx_on, 1);
        repeat (100) @(negedge clk);
        chk(st_tx_done == 1'b0, "R7 done low mid-frame", st_tx_done, 0);
        wait_done();
        chk(frames_seen == 2 && q.size() == 0, "R4 two frames, drop honoured", frames_seen, 2);
        chk(irq_flag == 1'b1, "R8 flag set on completion", irq_flag, 1);
        chk(irq_out == 1'b0, "R8 masked out", irq_out, 0);
        irq_mask = 1'b1; @(negedge clk);
        chk(irq_out == 1'b1, "R8 unmasked", irq_out, 1);
        @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        chk(irq_flag == 1'b0, "R8 cleared", irq_flag, 0);
        @(negedge clk); irq_set = 1'b1; @(negedge clk); irq_set = 1'b0;
        chk(irq_flag == 1'b1, "R8 set pulse", irq_flag, 1);
        @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;

        // other formats, back to back
        set_cfg(5, 1, 16); send(9'h013, 1); send(9'h1F5, 1); wait_done();
        set_cfg(7, 2, 32); send(9'h055, 1); send(9'h000, 1); wait_done();
        set_cfg(9, 0, 8);  send(9'h1AB, 1); send(9'h0FF, 1); wait_done();
        set_cfg(6, 2, 8);  send(9'h02A, 1); wait_done();
        chk(q.size() == 0 && frames_seen == 9, "R1 all format frames seen", frames_seen, 9);

        // off command wins over on command
        pulse_en(1, 1);
        chk(st_tx_on == 1'b0, "R6 off wins", st_tx_on, 1'b0);

        // write clears done; off mid-frame finishes current only
        set_cfg(8, 0, 16);
        send(9'h011, 0);
        @(negedge clk);
        chk(st_tx_done == 1'b0, "R7 write clears done", st_tx_done, 0);
        send(9'h022, 1);
        f0 = frames_seen;
        pulse_en(1, 0);
        while (txd) @(negedge clk);
        repeat (20) @(negedge clk);
        pulse_en(0, 1);
        repeat (1500) @(negedge clk);
        chk(frames_seen == f0 + 1, "R6 in-flight frame finished, next held", frames_seen, f0 + 1);
        chk(txd == 1'b1 && st_tx_done == 1'b0, "R7 done low, entry waiting", st_tx_done, 0);
        chk(st_buf_lvl == 1'b0, "R5 entry still held", st_buf_lvl, 0);
        pulse_en(1, 0);
        wait_done();
        chk(frames_seen == f0 + 2 && q.size() == 0, "R4 held entry sent", frames_seen, f0 + 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule